// File: doc/BRIEF.md
# Escaped byte-stream packet decoder

This block sits behind a serial shifter and receives one raw byte per cycle in which its valid input is high. It removes two layers of encoding. Link fill bytes (0x4A) are dropped wherever they occur. Byte stuffing is undone: a byte that follows either escape code (0x7D or 0x4D) is restored by XOR with 0x20. Packet framing is recognised from the start (0x7A), end (0x7B) and channel (0x7C) markers. The block delivers payload bytes with start-of-packet and end-of-packet flags, and it raises a one-cycle error pulse when the framing is broken.

In this framing the end marker does not close the packet. It announces that the next data byte is the last one, so that byte is delivered with the end flag set. Only channel 0 is accepted. A start marker that arrives inside a packet restarts decoding. After an error the partial packet is abandoned and every byte is discarded until the next start marker. The transaction layer above the block interprets the payload.

Top module: `esc_pkt_decoder`

## Requirements
- R1: While rst_ni is low, data_vld_o, sop_o, eop_o and err_o are all 0.
- R2: A valid input byte 0x4A is discarded in every state. It produces no output and does not alter the decoder state, not even when it follows an escape code or a channel marker.
- R3: While no packet is open (after reset, after a completed packet, or after an error), every valid byte other than 0x7A is discarded without output or error.
- R4: A data byte that follows 0x7D or 0x4D is output as that byte XOR 0x20. Any byte outside the set {0x7A, 0x7B, 0x7C, 0x7D, 0x4D, 0x4A} that does not follow an escape is output unchanged.
- R5: The first payload byte after a start marker is output with sop_o=1. Later payload bytes carry sop_o=0.
- R6: After an end marker (0x7B), the next payload byte is output with eop_o=1 and the packet closes.
- R7: The byte after a channel marker is a channel number and is not output. A value of 0x00 is accepted. Any other value raises err_o.
- R8: A start marker inside an open packet discards the partial packet and clears all pending escape, end and channel state. The next payload byte carries sop_o=1.
- R9: An escape code that directly follows an escape code raises err_o.
- R10: An end or channel marker that directly follows an escape code, or that follows an end marker still awaiting its final byte, raises err_o.
- R11: err_o is a single-cycle pulse and never coincides with data_vld_o. After it, the decoder is closed as described in R3.
- R12: Each output appears in the cycle after the clock edge that accepts the corresponding input byte. Cycles with byte_vld_i=0 change no state and produce no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_vld_i | input | 1 | Input byte valid |
| byte_i | input | 8 | Raw received byte |
| data_vld_o | output | 1 | Payload byte valid |
| data_o | output | 8 | Decoded payload byte |
| sop_o | output | 1 | First payload byte of a packet |
| eop_o | output | 1 | Last payload byte of a packet |
| err_o | output | 1 | Framing error pulse |

## Verification
Every internal flag of this decoder becomes visible on the ports at the next payload byte or error.

| Corrupted state | Symptom at the ports |
|---|---|
| Escape flag | An XOR-flipped data byte, or a spurious error on the next escape or marker |
| End flag | A misplaced eop_o, or an early or missing error |
| Channel flag | A leaked channel number, or an error against 0x00 |
| "Packet open" flag | Data leaking before a start marker, or bytes lost after one |

The reference model is compared on every cycle, so a fault surfaces one cycle after the byte that exposes it. A long mixed stream rich in special codes drives each flag through its combinations.

// File: rtl/esc_pkt_pkg.sv
package esc_pkt_pkg;
  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] CODE_SOP  = 8'h7A;
  localparam logic [BYTE_W-1:0] CODE_EOP  = 8'h7B;
  localparam logic [BYTE_W-1:0] CODE_CHAN = 8'h7C;
  localparam logic [BYTE_W-1:0] CODE_PESC = 8'h7D;
  localparam logic [BYTE_W-1:0] CODE_IDLE = 8'h4A;
  localparam logic [BYTE_W-1:0] CODE_LESC = 8'h4D;
  localparam logic [BYTE_W-1:0] ESC_MASK  = 8'h20;

  typedef enum logic [2:0] {
    CLS_DATA,
    CLS_IDLE,
    CLS_SOP,
    CLS_EOP,
    CLS_CHAN,
    CLS_ESC
  } byte_cls_e;

  typedef struct packed {
    logic open;   // packet in progress
    logic first;  // next payload byte is the first
    logic esc;    // escape pending
    logic eop;    // end marker seen, next byte is last
    logic chan;   // channel number expected
  } dec_st_t;
endpackage

// File: rtl/esc_byte_class.sv
module esc_byte_class
  import esc_pkt_pkg::*;
#(
  parameter int W = BYTE_W
) (
  input  logic [W-1:0] byte_i,
  output byte_cls_e    cls_o
);
  always_comb begin
    unique case (byte_i)
      CODE_IDLE:            cls_o = CLS_IDLE;
      CODE_SOP:             cls_o = CLS_SOP;
      CODE_EOP:             cls_o = CLS_EOP;
      CODE_CHAN:            cls_o = CLS_CHAN;
      CODE_PESC, CODE_LESC: cls_o = CLS_ESC;
      default:              cls_o = CLS_DATA;
    endcase
  end
endmodule

// File: rtl/esc_frame_seq.sv
module esc_frame_seq
  import esc_pkt_pkg::*;
#(
  parameter int W = BYTE_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         vld_i,
  input  byte_cls_e    cls_i,
  input  logic [W-1:0] byte_i,
  output logic         emit_o,
  output logic         emit_sop_o,
  output logic         emit_eop_o,
  output logic         flip_o,
  output logic         err_o
);
  localparam dec_st_t ST_IDLE  = '0;
  localparam dec_st_t ST_FRESH = '{open: 1'b1, first: 1'b1, esc: 1'b0, eop: 1'b0, chan: 1'b0};

  dec_st_t st_q, st_d;

  always_comb begin
    st_d   = st_q;
    emit_o = 1'b0;
    err_o  = 1'b0;
    if (vld_i) begin
      if (!st_q.open) begin
        if (cls_i == CLS_SOP) st_d = ST_FRESH;
      end else if (cls_i == CLS_IDLE) begin
        st_d = st_q;
      end else if (st_q.chan) begin
        if (byte_i != '0) err_o = 1'b1;
        else              st_d.chan = 1'b0;
      end else begin
        unique case (cls_i)
          CLS_SOP: st_d = ST_FRESH;
          CLS_EOP: begin
            if (st_q.esc || st_q.eop) err_o = 1'b1;
            else                      st_d.eop = 1'b1;
          end
          CLS_CHAN: begin
            if (st_q.esc || st_q.eop) err_o = 1'b1;
            else                      st_d.chan = 1'b1;
          end
          CLS_ESC: begin
            if (st_q.esc) err_o = 1'b1;
            else          st_d.esc = 1'b1;
          end
          default: begin
            emit_o      = 1'b1;
            st_d.esc    = 1'b0;
            st_d.first  = 1'b0;
            if (st_q.eop) st_d = ST_IDLE;
          end
        endcase
      end
      if (err_o) st_d = ST_IDLE;
    end
  end

  assign emit_sop_o = st_q.first;
  assign emit_eop_o = st_q.eop;
  assign flip_o     = st_q.esc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end
endmodule

// File: rtl/esc_out_stage.sv
module esc_out_stage
  import esc_pkt_pkg::*;
#(
  parameter int W = BYTE_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         emit_i,
  input  logic         sop_i,
  input  logic         eop_i,
  input  logic         flip_i,
  input  logic         err_i,
  input  logic [W-1:0] byte_i,
  output logic         vld_o,
  output logic [W-1:0] data_o,
  output logic         sop_o,
  output logic         eop_o,
  output logic         err_o
);
  logic [W-1:0] mask;
  assign mask = flip_i ? W'(ESC_MASK) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      data_o <= '0;
      sop_o  <= 1'b0;
      eop_o  <= 1'b0;
      err_o  <= 1'b0;
    end else begin
      vld_o <= emit_i;
      sop_o <= emit_i & sop_i;
      eop_o <= emit_i & eop_i;
      err_o <= err_i;
      if (emit_i) data_o <= byte_i ^ mask;
    end
  end
endmodule

// File: rtl/esc_pkt_decoder.sv
module esc_pkt_decoder
  import esc_pkt_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        byte_vld_i,
  input  logic [7:0]  byte_i,
  output logic        data_vld_o,
  output logic [7:0]  data_o,
  output logic        sop_o,
  output logic        eop_o,
  output logic        err_o
);
  localparam int W = BYTE_W;

  byte_cls_e cls;
  logic      emit, emit_sop, emit_eop, flip, seq_err;

  esc_byte_class #(.W(W)) i_class (
    .byte_i (byte_i),
    .cls_o  (cls)
  );

  esc_frame_seq #(.W(W)) i_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .vld_i      (byte_vld_i),
    .cls_i      (cls),
    .byte_i     (byte_i),
    .emit_o     (emit),
    .emit_sop_o (emit_sop),
    .emit_eop_o (emit_eop),
    .flip_o     (flip),
    .err_o      (seq_err)
  );

  esc_out_stage #(.W(W)) i_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .emit_i (emit),
    .sop_i  (emit_sop),
    .eop_i  (emit_eop),
    .flip_i (flip),
    .err_i  (seq_err),
    .byte_i (byte_i),
    .vld_o  (data_vld_o),
    .data_o (data_o),
    .sop_o  (sop_o),
    .eop_o  (eop_o),
    .err_o  (err_o)
  );
endmodule

// File: rtl/esc_pkt_decoder_chk.sv
module esc_pkt_decoder_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       byte_vld_i,
  input logic [7:0] byte_i,
  input logic       data_vld_o,
  input logic [7:0] data_o,
  input logic       sop_o,
  input logic       eop_o,
  input logic       err_o
);
  // set once a packet ends or fails, cleared by an incoming start marker
  logic need_sop_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) need_sop_q <= 1'b1;
    else if (byte_vld_i && byte_i == 8'h7A) need_sop_q <= 1'b0;
    else if (err_o || (data_vld_o && eop_o)) need_sop_q <= 1'b1;
  end

  always_comb begin
    if (!rst_ni) assert_reset_quiet_R1: assert (!data_vld_o && !err_o && !sop_o && !eop_o);
  end

  assert_idle_dropped_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_vld_i && byte_i == 8'h4A) |=> (!data_vld_o && !err_o));

  assert_open_needs_sop_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_vld_o && need_sop_q) |-> sop_o);

  assert_flags_with_data_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sop_o || eop_o) |-> data_vld_o);

  assert_err_exclusive_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !data_vld_o);

  assert_out_follows_in_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_vld_o || err_o) |-> $past(byte_vld_i));
endmodule

bind esc_pkt_decoder esc_pkt_decoder_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .byte_vld_i (byte_vld_i),
  .byte_i     (byte_i),
  .data_vld_o (data_vld_o),
  .data_o     (data_o),
  .sop_o      (sop_o),
  .eop_o      (eop_o),
  .err_o      (err_o)
);

// File: tb/test_esc_pkt_decoder.sv
module test_esc_pkt_decoder;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       byte_vld_i = 1'b0;
  logic [7:0] byte_i = 8'h00;
  logic       data_vld_o, sop_o, eop_o, err_o;
  logic [7:0] data_o;

  always #2 clk_i = ~clk_i;

  esc_pkt_decoder i_esc_pkt_decoder (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .byte_vld_i (byte_vld_i),
    .byte_i     (byte_i),
    .data_vld_o (data_vld_o),
    .data_o     (data_o),
    .sop_o      (sop_o),
    .eop_o      (eop_o),
    .err_o      (err_o)
  );

  int vectors = 0;
  int fails = 0;
  string cur_req = "R1";
  bit done = 0;

  // expected outputs for the byte driven last
  bit       e_vld = 0, e_sop = 0, e_eop = 0, e_err = 0;
  bit [7:0] e_data = 0;
  // model state
  bit m_open = 0, m_first = 0, m_esc = 0, m_eop = 0, m_chan = 0;

  function automatic bit is_special(input bit [7:0] b);
    return b == 8'h7A || b == 8'h7B || b == 8'h7C || b == 8'h7D ||
           b == 8'h4D || b == 8'h4A;
  endfunction

  task automatic model(input bit v, input bit [7:0] b);
    bit bad;
    e_vld = 0; e_sop = 0; e_eop = 0; e_err = 0;
    bad = 0;
    if (!v) return;
    if (!m_open) begin
      if (b == 8'h7A) begin m_open = 1; m_first = 1; m_esc = 0; m_eop = 0; m_chan = 0; end
      return;
    end
    if (b == 8'h4A) return;
    if (m_chan) begin
      if (b != 0) bad = 1; else m_chan = 0;
    end else if (b == 8'h7A) begin
      m_first = 1; m_esc = 0; m_eop = 0; m_chan = 0;
    end else if (b == 8'h7B || b == 8'h7C) begin
      if (m_esc || m_eop) bad = 1;
      else if (b == 8'h7B) m_eop = 1;
      else m_chan = 1;
    end else if (b == 8'h7D || b == 8'h4D) begin
      if (m_esc) bad = 1; else m_esc = 1;
    end else begin
      e_vld = 1;
      e_data = m_esc ? (b ^ 8'h20) : b;
      e_sop = m_first;
      e_eop = m_eop;
      m_first = 0; m_esc = 0;
      if (m_eop) m_open = 0;
    end
    if (bad) begin
      e_err = 1;
      m_open = 0; m_first = 0; m_esc = 0; m_eop = 0; m_chan = 0;
    end
  endtask

  task automatic compare();
    bit miss;
    vectors++;
    miss = (data_vld_o != e_vld) || (err_o != e_err) ||
           (e_vld && (data_o != e_data || sop_o != e_sop || eop_o != e_eop)) ||
           (!e_vld && (sop_o || eop_o));
    if (miss) begin
      fails++;
      $display("FAIL %s: got vld=%0b data=%02h sop=%0b eop=%0b err=%0b, expected vld=%0b data=%02h sop=%0b eop=%0b err=%0b",
               cur_req, data_vld_o, data_o, sop_o, eop_o, err_o,
               e_vld, e_data, e_sop, e_eop, e_err);
    end
  endtask

  task automatic step(input bit v, input bit [7:0] b);
    @(negedge clk_i);
    compare();
    byte_vld_i = v;
    byte_i = b;
    model(v, b);
  endtask

  task automatic send(input bit [7:0] b);
    step(1'b1, b);
  endtask

  task automatic gap(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 8'hA5);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk_i);
    fails++;
    $display("FAIL R12: watchdog expired, cycles=%0d expected<%0d", 50000, 50000);
    finish_run();
  end

  initial begin
    bit [15:0] lfsr;
    bit [7:0]  b;
    // R1 reset state, with input activity during reset
    cur_req = "R1";
    byte_vld_i = 1'b1;
    byte_i = 8'h7A;
    repeat (3) begin @(negedge clk_i); compare(); end
    byte_vld_i = 1'b0;
    @(negedge clk_i);
    compare();
    rst_ni = 1'b1;
    // R3 garbage before the first start marker
    cur_req = "R3";
    send(8'h11); send(8'h7B); send(8'h00); send(8'h7D); send(8'h55);
    // R5, R6, R2: basic packet with fill
    cur_req = "R5";
    send(8'h7A); send(8'h4A); send(8'h7C); send(8'h4A); send(8'h00); send(8'h10);
    cur_req = "R2";
    send(8'h4A); send(8'h20); send(8'h4A);
    cur_req = "R6";
    send(8'h7B); send(8'h4A); send(8'h30);
    // R6 closed after the last byte
    send(8'h55); send(8'h66);
    // R4 both escape codes, escape followed by fill
    cur_req = "R4";
    send(8'h7A); send(8'h7D); send(8'h5A); send(8'h4D); send(8'h4A); send(8'h6A);
    send(8'h7B); send(8'h4D); send(8'h6D);
    // R12 gaps with vld low mid packet
    cur_req = "R12";
    send(8'h7A); gap(3); send(8'h01); gap(2); send(8'h7B); gap(1); send(8'h02); gap(2);
    // R7 channel number checks
    cur_req = "R7";
    send(8'h7A); send(8'h7C); send(8'h00); send(8'h44);
    send(8'h7C); send(8'h01);
    cur_req = "R11";
    send(8'h33); send(8'h7B); send(8'h34);
    // R8 restart in the middle of a packet with pending state
    cur_req = "R8";
    send(8'h7A); send(8'h11); send(8'h22); send(8'h7D); send(8'h7A); send(8'h33);
    send(8'h7B); send(8'h7A); send(8'h44); send(8'h7B); send(8'h45);
    // R9 escape after escape
    cur_req = "R9";
    send(8'h7A); send(8'h7D); send(8'h4D); send(8'h12);
    // R10 marker after escape or after end marker
    cur_req = "R10";
    send(8'h7A); send(8'h7D); send(8'h7B);
    send(8'h7A); send(8'h4D); send(8'h7C);
    send(8'h7A); send(8'h7B); send(8'h7B);
    send(8'h7A); send(8'h7B); send(8'h7C);
    // R5/R6 single-byte packet
    cur_req = "R6";
    send(8'h7A); send(8'h7B); send(8'h56); gap(2);
    // mixed stream rich in special codes
    cur_req = "R4";
    lfsr = 16'hACE1;
    for (int i = 0; i < 4000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (lfsr[2:0])
        3'd0: b = 8'h7A;
        3'd1: b = 8'h7B;
        3'd2: b = 8'h7C;
        3'd3: b = lfsr[8] ? 8'h7D : 8'h4D;
        3'd4: b = 8'h4A;
        3'd5: b = 8'h00;
        default: b = lfsr[13:6];
      endcase
      step(lfsr[15:14] != 2'b00, b);
    end
    gap(3);
    finish_run();
  end
endmodule